// File: doc/BRIEF.md
# Interrupt Cause and Enable Unit

This block keeps the interrupt cause register and the interrupt enable register of a storage host adapter, both reached over a 32-bit register port with byte addresses and whole-word accesses. Completion logic and the message path inside the adapter report events on single-cycle strobes. Each strobe sets its own cause bit. Software acknowledges causes by writing ones to the cause register. It picks which causes may interrupt by writing the enable register.

After every change to causes or enables, the block evaluates the interrupt condition on the following clock. That condition is true when any cause bit is also enabled. With message-signalled delivery selected, a true evaluation yields a one-clock notify pulse. Otherwise the level line takes the evaluated value. Each acknowledge that arrives while completions are still waiting also raises a one-cycle retry request toward the completion logic. The adapter's soft reset clears the causes and leaves the enables unchanged.

Top module: `irq_status_unit`

## Requirements
- R1: After `rst_n` is released, the cause register reads 0, the enable register reads 0, and `irqLevel`, `msiNotify` and `cmplRetry` are all low.
- R2: Writing byte offset 0x08 clears each cause bit that is 1 in the write data. Cause bits that are 0 in the write data keep their value.
- R3: Writing byte offset 0x0C replaces all 32 bits of the enable register with the write data.
- R4: A `cmplEvent` strobe sets cause bit 0 and a `msgEvent` strobe sets cause bit 2. When an event and a cause write arrive in the same cycle, the event's bit ends up set.
- R5: The following all trigger an evaluation on the next clock edge: a cause write, an enable write, an event strobe, or `adapterReset`. With `msiEnable` low, that evaluation sets `irqLevel` to the OR of (enable AND cause).
- R6: With `msiEnable` high, an evaluation whose condition is true drives `msiNotify` high for exactly one cycle. An evaluation whose condition is false produces no pulse, and `irqLevel` is low after any evaluation made in this mode.
- R7: A cause write while `cmplQueued` is high makes `cmplRetry` high for one cycle, starting at the edge that takes the write. A cause write with `cmplQueued` low, and an enable write, produce no retry.
- R8: Reads are combinational. Offset 0x08 returns the cause register, 0x0C returns the enable register, and 0x10 returns `cmdStatusIn`. Any other address, including one that is not a multiple of 4, reads 0, and a write to such an address changes nothing.
- R9: `adapterReset` clears the cause register, even when an event strobe arrives in the same cycle, and leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the register port |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| cmdStatusIn | input | 32 | Command-status value exposed for reading |
| cmplEvent | input | 1 | Completion event strobe |
| msgEvent | input | 1 | Message event strobe |
| adapterReset | input | 1 | Soft reset that clears the cause register |
| cmplQueued | input | 1 | Completions are still waiting to be posted |
| msiEnable | input | 1 | Selects message-signalled delivery |
| irqLevel | output | 1 | Level interrupt line |
| msiNotify | output | 1 | One-cycle message-signalled notify |
| cmplRetry | output | 1 | One-cycle request to rerun completion processing |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, the cause register at 0x08, the enable register at 0x0C and command status at 0x10. It sweeps all 16 patterns of the low four enable bits against all four combinations of the two causes. The sweep runs once with level delivery and once with message-signalled delivery. The low enable bits include the two cause positions and two bits next to them that are never set, so the sweep reaches every result of the AND-reduction the design can produce. Directed steps cover these remaining cases: event-versus-clear collisions, soft reset racing an event, misaligned and unmapped addresses, and the retry pulse with and without queued completions.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdStatus;
    logic rdMask;
    logic rdCmd;
    logic evalNow;
  } irqStrobes_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFF = 8,
  parameter int MASK_OFF   = 12,
  parameter int CMD_OFF    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              cmplEvent,
  input  logic              msgEvent,
  input  logic              adapterReset,
  input  logic              cmplQueued,
  output irqStrobes_t       strobes,
  output logic              cmplRetry
);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFF);
  localparam logic [ADDR_W-1:0] MASK_A   = ADDR_W'(MASK_OFF);
  localparam logic [ADDR_W-1:0] CMD_A    = ADDR_W'(CMD_OFF);

  logic hitStatus, hitMask, hitCmd;
  logic evalQ, retryQ, changeNow;

  // Only exact word offsets decode, so unaligned addresses hit nothing.
  assign hitStatus = (regAddr == STATUS_A);
  assign hitMask   = (regAddr == MASK_A);
  assign hitCmd    = (regAddr == CMD_A);

  assign changeNow = strobes.wrStatus | strobes.wrMask | cmplEvent | msgEvent | adapterReset;

  always_comb begin
    strobes.wrStatus = regWrEn & hitStatus;
    strobes.wrMask   = regWrEn & hitMask;
    strobes.rdStatus = hitStatus;
    strobes.rdMask   = hitMask;
    strobes.rdCmd    = hitCmd;
    strobes.evalNow  = evalQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evalQ  <= 1'b0;
      retryQ <= 1'b0;
    end else begin
      evalQ  <= changeNow;
      retryQ <= strobes.wrStatus & cmplQueued;
    end
  end

  assign cmplRetry = retryQ;

  // R7: a retry only follows a queued acknowledge
  a_r7_retry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmplRetry |-> ($past(regWrEn) && $past(cmplQueued)));
  a_r7_no_retry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmplQueued |=> !cmplRetry);
  // R5: every change schedules an evaluation
  a_r5_eval_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmplEvent || msgEvent) |=> strobes.evalNow);
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int CMPL_BIT = 0,
  parameter int MSG_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqStrobes_t       strobes,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] cmdStatusIn,
  input  logic              cmplEvent,
  input  logic              msgEvent,
  input  logic              adapterReset,
  input  logic              msiEnable,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqLevel,
  output logic              msiNotify
);
  localparam logic [DATA_W-1:0] CMPL_SET = DATA_W'(1) << CMPL_BIT;
  localparam logic [DATA_W-1:0] MSG_SET  = DATA_W'(1) << MSG_BIT;

  logic [DATA_W-1:0] statusQ, statusNext, maskQ;
  logic irqQ, notifyQ, pending;

  always_comb begin
    statusNext = statusQ;
    if (strobes.wrStatus) statusNext = statusNext & ~regWrData;
    if (cmplEvent)        statusNext = statusNext | CMPL_SET;
    if (msgEvent)         statusNext = statusNext | MSG_SET;
    if (adapterReset)     statusNext = '0;
  end

  assign pending = |(statusQ & maskQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= '0;
      maskQ   <= '0;
      irqQ    <= 1'b0;
      notifyQ <= 1'b0;
    end else begin
      statusQ <= statusNext;
      if (strobes.wrMask) maskQ <= regWrData;
      if (strobes.evalNow) begin
        irqQ    <= pending & ~msiEnable;
        notifyQ <= pending & msiEnable;
      end else begin
        notifyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (strobes.rdStatus)   regRdData = statusQ;
    else if (strobes.rdMask) regRdData = maskQ;
    else if (strobes.rdCmd)  regRdData = cmdStatusIn;
  end

  assign irqLevel  = irqQ;
  assign msiNotify = notifyQ;

  // R2: acknowledged bits are gone unless something set them again
  a_r2_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrStatus && !cmplEvent && !msgEvent && !adapterReset)
      |=> ((statusQ & $past(regWrData)) == '0));
  // R3: enable write takes the full word
  a_r3_mask_replace: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrMask |=> (maskQ == $past(regWrData)));
  // R4: completion event always lands unless soft reset
  a_r4_cmpl_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmplEvent && !adapterReset) |=> statusQ[CMPL_BIT]);
  a_r4_msg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (msgEvent && !adapterReset) |=> statusQ[MSG_BIT]);
  // R6: a notify comes only from an evaluation in message mode
  a_r6_notify_origin: assert property (@(posedge clk) disable iff (!rst_n)
    msiNotify |-> ($past(strobes.evalNow) && $past(msiEnable)));
  a_r6_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.evalNow && msiEnable) |=> !irqLevel);
  // R9: soft reset empties causes, keeps enables
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    adapterReset |=> (statusQ == '0));
  a_r9_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (adapterReset && !strobes.wrMask) |=> (maskQ == $past(maskQ)));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFF = 8,
  parameter int MASK_OFF   = 12,
  parameter int CMD_OFF    = 16,
  parameter int CMPL_BIT   = 0,
  parameter int MSG_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       cmdStatusIn,
  input  logic              cmplEvent,
  input  logic              msgEvent,
  input  logic              adapterReset,
  input  logic              cmplQueued,
  input  logic              msiEnable,
  output logic              irqLevel,
  output logic              msiNotify,
  output logic              cmplRetry
);
  irqStrobes_t strobes;

  irq_status_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFF(STATUS_OFF), .MASK_OFF(MASK_OFF), .CMD_OFF(CMD_OFF)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .cmplEvent(cmplEvent), .msgEvent(msgEvent), .adapterReset(adapterReset),
    .cmplQueued(cmplQueued), .strobes(strobes), .cmplRetry(cmplRetry)
  );

  irq_status_dp #(
    .CMPL_BIT(CMPL_BIT), .MSG_BIT(MSG_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regWrData(regWrData),
    .cmdStatusIn(cmdStatusIn), .cmplEvent(cmplEvent), .msgEvent(msgEvent),
    .adapterReset(adapterReset), .msiEnable(msiEnable), .regRdData(regRdData),
    .irqLevel(irqLevel), .msiNotify(msiNotify)
  );
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_MASK = 8'h0C;
  localparam logic [7:0] A_CMD  = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] cmdStatusIn = 32'h1234_5678;
  logic cmplEvent = 1'b0, msgEvent = 1'b0, adapterReset = 1'b0;
  logic cmplQueued = 1'b0, msiEnable = 1'b0;
  logic irqLevel, msiNotify, cmplRetry;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cmdStatusIn(cmdStatusIn),
    .cmplEvent(cmplEvent), .msgEvent(msgEvent), .adapterReset(adapterReset),
    .cmplQueued(cmplQueued), .msiEnable(msiEnable), .irqLevel(irqLevel),
    .msiNotify(msiNotify), .cmplRetry(cmplRetry)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the edge that samples it
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic ce, input logic me, input logic ar);
    regWrEn = w; regAddr = a; regWrData = d;
    cmplEvent = ce; msgEvent = me; adapterReset = ar;
    @(negedge clk);
    regWrEn = 1'b0; cmplEvent = 1'b0; msgEvent = 1'b0; adapterReset = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({31'd0, irqLevel}, 0, "R1 irqLevel");
    chk({31'd0, msiNotify}, 0, "R1 msiNotify");
    chk({31'd0, cmplRetry}, 0, "R1 cmplRetry");
    rd(A_STAT, v); chk(v, 0, "R1 status");
    rd(A_MASK, v); chk(v, 0, "R1 mask");

    // R3 mask replace
    step(1, A_MASK, 32'hA5A5_5A5A, 0, 0, 0);
    rd(A_MASK, v); chk(v, 32'hA5A5_5A5A, "R3 mask full");
    step(1, A_MASK, 32'h0000_00F0, 0, 0, 0);
    rd(A_MASK, v); chk(v, 32'h0000_00F0, "R3 mask replaced");

    // R4 events
    step(0, A_CMD, 0, 1, 0, 0);
    rd(A_STAT, v); chk(v, 32'h1, "R4 cmpl bit0");
    step(0, A_CMD, 0, 0, 1, 0);
    rd(A_STAT, v); chk(v, 32'h5, "R4 msg bit2");

    // R2 write-one-to-clear
    step(1, A_STAT, 32'h1, 0, 0, 0);
    rd(A_STAT, v); chk(v, 32'h4, "R2 clear bit0 only");
    step(1, A_STAT, 32'h0, 0, 0, 0);
    rd(A_STAT, v); chk(v, 32'h4, "R2 zero write keeps");
    step(1, A_STAT, 32'hFFFF_FFFF, 0, 0, 0);
    rd(A_STAT, v); chk(v, 32'h0, "R2 clear all");
    step(1, A_STAT, 32'hFFFF_FFFF, 1, 0, 0);
    rd(A_STAT, v); chk(v, 32'h1, "R4 event beats clear");
    step(1, A_STAT, 32'hFFFF_FFFF, 0, 0, 0);

    // R8 read map and unmapped/misaligned
    rd(A_CMD, v); chk(v, 32'h1234_5678, "R8 cmd status");
    rd(8'h14, v); chk(v, 0, "R8 unmapped read");
    step(1, A_MASK, 32'h3, 0, 0, 0);
    rd(8'h0D, v); chk(v, 0, "R8 misaligned read");
    step(1, 8'h0D, 32'hFFFF_0000, 0, 0, 0);
    rd(A_MASK, v); chk(v, 32'h3, "R8 misaligned write ignored");

    // R5 level sweep
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] st;
        st = (c[0] ? 32'h1 : 32'h0) | (c[1] ? 32'h4 : 32'h0);
        step(1, A_STAT, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, A_MASK, 32'(m), 0, 0, 0);
        step(0, A_CMD, 0, c[0], c[1], 0);
        @(negedge clk);
        chk({31'd0, irqLevel}, {31'd0, |(st & 32'(m))}, "R5 level sweep");
        chk({31'd0, msiNotify}, 0, "R5 no notify in level mode");
      end
    end
    // R5 level drops after acknowledge
    step(1, A_MASK, 32'h1, 0, 0, 0);
    step(0, A_CMD, 0, 1, 0, 0);
    @(negedge clk);
    chk({31'd0, irqLevel}, 1, "R5 level high");
    step(1, A_STAT, 32'h1, 0, 0, 0);
    @(negedge clk);
    chk({31'd0, irqLevel}, 0, "R5 level low after ack");

    // R6 message-signalled sweep
    msiEnable = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] st;
        st = (c[0] ? 32'h1 : 32'h0) | (c[1] ? 32'h4 : 32'h0);
        step(1, A_STAT, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, A_MASK, 32'(m), 0, 0, 0);
        step(0, A_CMD, 0, c[0], c[1], 0);
        @(negedge clk);
        chk({31'd0, msiNotify}, {31'd0, |(st & 32'(m))}, "R6 notify sweep");
        chk({31'd0, irqLevel}, 0, "R6 level low in msg mode");
        @(negedge clk);
        chk({31'd0, msiNotify}, 0, "R6 pulse one cycle");
      end
    end
    msiEnable = 1'b0;

    // R7 retry
    cmplQueued = 1'b1;
    step(1, A_STAT, 32'h0, 0, 0, 0);
    chk({31'd0, cmplRetry}, 1, "R7 retry pulse");
    @(negedge clk);
    chk({31'd0, cmplRetry}, 0, "R7 retry one cycle");
    step(1, A_MASK, 32'h5, 0, 0, 0);
    chk({31'd0, cmplRetry}, 0, "R7 no retry on mask write");
    cmplQueued = 1'b0;
    step(1, A_STAT, 32'h0, 0, 0, 0);
    chk({31'd0, cmplRetry}, 0, "R7 no retry when empty");

    // R9 soft reset
    step(1, A_MASK, 32'hF, 0, 0, 0);
    step(0, A_CMD, 0, 1, 1, 0);
    step(0, A_CMD, 0, 0, 0, 1);
    rd(A_STAT, v); chk(v, 0, "R9 status cleared");
    rd(A_MASK, v); chk(v, 32'hF, "R9 mask kept");
    step(0, A_CMD, 0, 1, 0, 1);
    rd(A_STAT, v); chk(v, 0, "R9 reset beats event");
    @(negedge clk);
    chk({31'd0, irqLevel}, 0, "R9 level low after soft reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule